// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable stand-in for a 128-byte serial EEPROM that sits on a three-wire bus. The bus has a chip select, a serial clock and a data-in line, plus one data-out line. A host frames each command as a start bit, a two-bit opcode and an address. The block decodes the command, and it reads, writes or changes its write-enable state. After each programming operation it reports a busy period on the data-out line.

A strap input selects how the storage is organised: 64 words of 16 bits or 128 bytes. A second strap selects an extended-instruction mode. In that mode a read returns only the addressed location, and the special commands need two extra clock bits before they act. Everything runs on one system clock. The serial clock is sampled as data, and its rising edges are detected inside the block, so each serial-clock phase must last at least two system clocks.

Top module: `mwEeprom`

## Requirements
- R1: A command is accepted only while chip select is high. Zero bits before the first 1 (the start bit) are ignored. After the start bit come a 2-bit opcode (10 read, 01 write, 00 special) and an address field, both MSB first: 7 bits in byte organisation (`wordMode`=0) or 6 bits in word organisation (`wordMode`=1). Opcode 11 is ignored.
- R2: In byte organisation the array is 128 x 8; in word organisation it is 64 x 16. Byte address 2k is the upper 8 bits of word k, and byte address 2k+1 is the lower 8 bits.
- R3: After the last address bit of a read, `serOut` shows a 0 dummy bit. Each further serial-clock rising edge then presents the next data bit, MSB first.
- R4: With `extInstr`=0, clocking past the last bit of a location continues with the next location, with no dummy bit in between. The address wraps from the last location to 0.
- R5: With `extInstr`=1, the next rising edge after the last data bit of a read drives `serOut` to 0, and no further data follows.
- R6: A write takes its data (8 or 16 bits, MSB first) right after the address. It changes the location only while the write-enable latch is set; otherwise the location keeps its value.
- R7: The two top bits of the address field in a special command pick the action: 11 sets the write-enable latch, 00 clears it, 10 erases the whole array, and 01 does nothing. The latch is cleared by reset.
- R8: Erase-all, with the latch set, makes every byte 0xFF.
- R9: With `extInstr`=1, a special command acts only after two more serial-clock bits follow the address. A special command that is cut short by chip select going low has no effect.
- R10: A write or erase-all that takes effect starts a busy period of `PROG_CYCLES` system clocks. While busy, `serOut` is 0 whenever chip select is high, and start bits are ignored.
- R11: Once the busy period has ended and chip select is high, `serOut` is 1 until the next start bit is accepted. After reset, `serOut` is 0.
- R12: Chip select going low abandons any partly received command. An abandoned write leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipSel | input | 1 | Chip select, active high |
| serClk | input | 1 | Serial clock, sampled by `clk` |
| serIn | input | 1 | Serial data from the host |
| wordMode | input | 1 | Organisation strap: 1 selects 16-bit words, 0 selects bytes |
| extInstr | input | 1 | 1 selects single-location reads and two trailing bits on special commands |
| serOut | output | 1 | Serial data and ready/busy status to the host |

## Verification
The busy countdown of a finished program operation and the arrival of a new command can overlap in time. The bench provokes this by raising chip select again right after a write and clocking in a full write to a different address before the countdown ends. The command must be dropped, so `serOut` must stay low, and a later read must return the old value at that address. The bench then waits out the countdown and checks that `serOut` rises only after the countdown ends. It also sends a start bit and checks that `serOut` falls again.

// File: rtl/mwPkg.sv
package mwPkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_HDR,
    ST_DEC,
    ST_WDATA,
    ST_XTRA,
    ST_EXEC,
    ST_READ,
    ST_DONE
  } mwState_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_WRITE,
    ACT_WEN,
    ACT_WDIS,
    ACT_ERAL
  } mwAct_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic latchAddr;
    logic loadOut;
    logic advance;
    logic shiftOut;
    logic writeWord;
    logic eraseAll;
  } mwStrobe_t;

endpackage

// File: rtl/mwDatapath.sv
module mwDatapath
  import mwPkg::*;
#(
  parameter int BYTES = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordMode,
  input  logic       serIn,
  input  mwStrobe_t  strb,
  output logic [4:0] hdrField,
  output logic       dataOut
);

  localparam int AW = $clog2(BYTES);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-2:0] WONE = (AW-1)'(1);

  logic [7:0]    mem [BYTES];
  logic [15:0]   inSr;
  logic [15:0]   outSr;
  logic [AW-1:0] addrReg;
  logic [AW-1:0] hdrAddr;
  logic [AW-1:0] addrInc;
  logic [AW-1:0] addrNext;
  logic [AW-2:0] wordIdx;
  logic [AW-2:0] wordIdxNext;
  logic [15:0]   rdWord;

  always_comb begin
    wordIdx     = addrReg[AW-2:0];
    wordIdxNext = wordIdx + WONE;
    hdrAddr     = wordMode ? {1'b0, inSr[AW-2:0]} : inSr[AW-1:0];
    addrInc     = wordMode ? {1'b0, wordIdxNext} : addrReg + ONE;
    if (strb.latchAddr)    addrNext = hdrAddr;
    else if (strb.advance) addrNext = addrInc;
    else                   addrNext = addrReg;
    if (wordMode)
      rdWord = {mem[{addrNext[AW-2:0], 1'b0}], mem[{addrNext[AW-2:0], 1'b1}]};
    else
      rdWord = {mem[addrNext], 8'h00};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSr    <= '0;
      outSr   <= '0;
      addrReg <= '0;
    end else begin
      if (strb.shiftIn) inSr <= {inSr[14:0], serIn};
      addrReg <= addrNext;
      if (strb.loadOut)       outSr <= rdWord;
      else if (strb.shiftOut) outSr <= {outSr[14:0], 1'b0};
    end
  end

  // array has no reset: contents persist across reset
  always_ff @(posedge clk) begin
    if (strb.eraseAll) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
    end else if (strb.writeWord) begin
      if (wordMode) begin
        mem[{wordIdx, 1'b0}] <= inSr[15:8];
        mem[{wordIdx, 1'b1}] <= inSr[7:0];
      end else begin
        mem[addrReg] <= inSr[7:0];
      end
    end
  end

  assign hdrField = inSr[8:4];
  assign dataOut  = outSr[15];

  AST_ERASE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseAll |=> (mem[0] == 8'hFF && mem[BYTES-1] == 8'hFF)); // R8

endmodule

// File: rtl/mwControl.sv
module mwControl
  import mwPkg::*;
#(
  parameter int PROG_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSel,
  input  logic       serClk,
  input  logic       serIn,
  input  logic       wordMode,
  input  logic       extInstr,
  input  logic [4:0] hdrField,
  input  logic       dataOut,
  output mwStrobe_t  strb,
  output logic       serOut
);

  localparam int BW = $clog2(PROG_CYCLES + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(PROG_CYCLES);
  localparam logic [BW-1:0] BONE = BW'(1);

  mwState_t      state;
  mwAct_t        act;
  logic          skPrev;
  logic          skRise;
  logic [4:0]    bitCnt;
  logic          dummy;
  logic          wen;
  logic          statusPend;
  logic [BW-1:0] busyCnt;
  logic          busy;
  logic [4:0]    hdrLast;
  logic [4:0]    dataLast;
  logic [1:0]    opcode;
  logic [1:0]    subCode;
  logic          wordEnd;

  always_comb begin
    skRise   = serClk && !skPrev && chipSel;
    busy     = (busyCnt != '0);
    hdrLast  = wordMode ? 5'd7 : 5'd8;
    dataLast = wordMode ? 5'd15 : 5'd7;
    opcode   = wordMode ? hdrField[3:2] : hdrField[4:3];
    subCode  = wordMode ? hdrField[1:0] : hdrField[2:1];
    wordEnd  = (state == ST_READ) && skRise && !dummy && (bitCnt == dataLast);

    strb           = '0;
    strb.shiftIn   = skRise && (state == ST_HDR || state == ST_WDATA || state == ST_XTRA);
    strb.latchAddr = chipSel && (state == ST_DEC);
    strb.advance   = wordEnd && !extInstr;
    strb.loadOut   = (chipSel && state == ST_DEC && opcode == 2'b10) || strb.advance;
    strb.shiftOut  = (state == ST_READ) && skRise && !dummy && (bitCnt != dataLast);
    strb.writeWord = chipSel && (state == ST_EXEC) && (act == ACT_WRITE) && wen;
    strb.eraseAll  = chipSel && (state == ST_EXEC) && (act == ACT_ERAL) && wen;

    if (!chipSel)               serOut = 1'b0;
    else if (state == ST_READ)  serOut = !dummy && dataOut;
    else                        serOut = (state == ST_WAIT) && !busy && statusPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      skPrev     <= 1'b0;
      state      <= ST_WAIT;
      act        <= ACT_NONE;
      bitCnt     <= '0;
      dummy      <= 1'b0;
      wen        <= 1'b0;
      statusPend <= 1'b0;
      busyCnt    <= '0;
    end else begin
      skPrev <= serClk;
      if (busy) busyCnt <= busyCnt - BONE;
      if (!chipSel) begin
        state <= ST_WAIT;
      end else begin
        case (state)
          ST_WAIT: if (skRise && !busy && serIn) begin
            state      <= ST_HDR;
            bitCnt     <= '0;
            statusPend <= 1'b0;
          end
          ST_HDR: if (skRise) begin
            if (bitCnt == hdrLast) state <= ST_DEC;
            else bitCnt <= bitCnt + 5'd1;
          end
          ST_DEC: begin
            bitCnt <= '0;
            case (opcode)
              2'b10: begin state <= ST_READ; dummy <= 1'b1; end
              2'b01: begin state <= ST_WDATA; act <= ACT_WRITE; end
              2'b00: begin
                state <= extInstr ? ST_XTRA : ST_EXEC;
                case (subCode)
                  2'b11:   act <= ACT_WEN;
                  2'b00:   act <= ACT_WDIS;
                  2'b10:   act <= ACT_ERAL;
                  default: act <= ACT_NONE;
                endcase
              end
              default: state <= ST_DONE;
            endcase
          end
          ST_WDATA: if (skRise) begin
            if (bitCnt == dataLast) state <= ST_EXEC;
            else bitCnt <= bitCnt + 5'd1;
          end
          ST_XTRA: if (skRise) begin
            if (bitCnt == 5'd1) state <= ST_EXEC;
            else bitCnt <= bitCnt + 5'd1;
          end
          ST_EXEC: begin
            state <= ST_DONE;
            case (act)
              ACT_WEN:  wen <= 1'b1;
              ACT_WDIS: wen <= 1'b0;
              ACT_WRITE, ACT_ERAL: if (wen) begin
                busyCnt    <= BUSY_LOAD;
                statusPend <= 1'b1;
              end
              default: ;
            endcase
          end
          ST_READ: if (skRise) begin
            if (dummy) dummy <= 1'b0;
            else if (bitCnt == dataLast) begin
              bitCnt <= '0;
              if (extInstr) state <= ST_DONE;
            end else bitCnt <= bitCnt + 5'd1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> state == ST_WAIT); // R12
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeWord || strb.eraseAll) |=> busy); // R10
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !serOut); // R10
  AST_BUSY_NOSTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state == ST_WAIT) |=> state == ST_WAIT); // R10
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.writeWord, strb.eraseAll, strb.shiftOut, strb.shiftIn})); // R6

endmodule

// File: rtl/mwEeprom.sv
module mwEeprom
  import mwPkg::*;
#(
  parameter int BYTES       = 128,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic serClk,
  input  logic serIn,
  input  logic wordMode,
  input  logic extInstr,
  output logic serOut
);

  mwStrobe_t  strb;
  logic [4:0] hdrField;
  logic       dataOut;

  mwControl #(.PROG_CYCLES(PROG_CYCLES)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSel  (chipSel),
    .serClk   (serClk),
    .serIn    (serIn),
    .wordMode (wordMode),
    .extInstr (extInstr),
    .hdrField (hdrField),
    .dataOut  (dataOut),
    .strb     (strb),
    .serOut   (serOut)
  );

  mwDatapath #(.BYTES(BYTES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wordMode (wordMode),
    .serIn    (serIn),
    .strb     (strb),
    .hdrField (hdrField),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/sim_mwEeprom.sv
module sim_mwEeprom;

  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0;
  logic serClk = 1'b0;
  logic serIn = 1'b0;
  logic wordMode = 1'b0;
  logic extInstr = 1'b0;
  logic serOut;

  int nChk = 0;
  int nFail = 0;
  logic [7:0] model [128];
  logic modelWen = 1'b0;

  always #5 clk = ~clk;

  mwEeprom #(.BYTES(128), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk),
    .serIn(serIn), .wordMode(wordMode), .extInstr(extInstr), .serOut(serOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b, output logic so);
    serIn = b;
    tick(1);
    serClk = 1'b1;
    tick(4);
    serClk = 1'b0;
    tick(4);
    so = serOut;
  endtask

  task automatic send(input logic b);
    logic so;
    pulse(b, so);
  endtask

  task automatic csOn();
    chipSel = 1'b1;
    tick(2);
  endtask

  task automatic csOff();
    serIn = 1'b0;
    chipSel = 1'b0;
    tick(3);
  endtask

  function automatic int addrW();
    return wordMode ? 6 : 7;
  endfunction

  function automatic int dataW();
    return wordMode ? 16 : 8;
  endfunction

  function automatic logic [15:0] expWord(input int a);
    if (wordMode) return {model[2*(a%64)], model[2*(a%64)+1]};
    return {8'h00, model[a%128]};
  endfunction

  task automatic sendHdr(input logic [1:0] op, input int addr, input int lead);
    for (int i = 0; i < lead; i++) send(1'b0);
    send(1'b1);
    send(op[1]);
    send(op[0]);
    for (int i = addrW() - 1; i >= 0; i--) send(addr[i]);
  endtask

  task automatic readOp(input int addr, input int nWords, input string req);
    logic so;
    logic [15:0] got;
    int a;
    a = addr;
    csOn();
    sendHdr(2'b10, addr, 0);
    check({req, " R3 dummy"}, {15'd0, serOut}, 16'd0);
    for (int w = 0; w < nWords; w++) begin
      got = '0;
      for (int i = 0; i < dataW(); i++) begin
        pulse(1'b0, so);
        got = {got[14:0], so};
      end
      check(req, got, expWord(a));
      a = (a + 1) % (wordMode ? 64 : 128);
    end
    if (extInstr) begin
      pulse(1'b0, so);
      check("R5 end of single read", {15'd0, so}, 16'd0);
    end
    csOff();
  endtask

  task automatic modelWrite(input int addr, input logic [15:0] data);
    if (!modelWen) return;
    if (wordMode) begin
      model[2*addr]   = data[15:8];
      model[2*addr+1] = data[7:0];
    end else begin
      model[addr] = data[7:0];
    end
  endtask

  task automatic writeBits(input int addr, input logic [15:0] data, input int lead);
    sendHdr(2'b01, addr, lead);
    for (int i = dataW() - 1; i >= 0; i--) send(data[i]);
    tick(2);
  endtask

  task automatic writeOp(input int addr, input logic [15:0] data, input int lead);
    csOn();
    writeBits(addr, data, lead);
    csOff();
    modelWrite(addr, data);
    tick(PROG + 5);
  endtask

  task automatic special(input logic [1:0] sub, input logic full);
    csOn();
    sendHdr(2'b00, int'(sub) << (addrW() - 2), 0);
    if (extInstr && full) begin
      send(1'b0);
      send(1'b0);
    end
    tick(2);
    csOff();
    if (!extInstr || full) begin
      if (sub == 2'b11) modelWen = 1'b1;
      if (sub == 2'b00) modelWen = 1'b0;
      if (sub == 2'b10 && modelWen) begin
        for (int i = 0; i < 128; i++) model[i] = 8'hFF;
        tick(PROG + 5);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    int a;
    logic [15:0] d;
    void'($urandom(32'd7301));
    tick(4);
    rstN = 1'b1;
    tick(2);
    check("R11 reset output", {15'd0, serOut}, 16'd0);

    // fill array, then reset to prove the latch powers up clear (R7)
    special(2'b11, 1'b1);
    special(2'b10, 1'b1);                      // R8
    readOp(0, 3, "R8 erased bytes");
    rstN = 1'b0; tick(3); rstN = 1'b1; tick(2);
    modelWen = 1'b0;
    writeOp(9, 16'h0042, 0);
    readOp(9, 1, "R7 latch clear after reset");

    // enable, byte writes, leading zeros (R1)
    special(2'b11, 1'b1);
    writeOp(5, 16'h00C3, 3);
    readOp(5, 1, "R1 leading zeros");
    writeOp(127, 16'h005A, 0);
    writeOp(0, 16'h0011, 0);
    readOp(127, 3, "R4 byte wrap");

    // word organisation and cross-view (R2)
    wordMode = 1'b1;
    writeOp(3, 16'hA55A, 0);
    writeOp(63, 16'h1234, 0);
    readOp(63, 2, "R4 word wrap");
    wordMode = 1'b0;
    readOp(6, 2, "R2 byte view of word");

    // write with latch cleared (R6, R7)
    special(2'b00, 1'b1);
    writeOp(6, 16'h0077, 0);
    readOp(6, 1, "R6 write ignored when disabled");
    special(2'b01, 1'b1);
    writeOp(6, 16'h0077, 0);
    readOp(6, 1, "R7 code 01 no effect");

    // extended mode (R5, R9)
    extInstr = 1'b1;
    special(2'b11, 1'b1);
    special(2'b00, 1'b0);                      // cut short: latch stays set
    writeOp(20, 16'h003C, 0);
    readOp(20, 1, "R9 truncated disable");
    special(2'b00, 1'b1);
    writeOp(20, 16'h00C0, 0);
    readOp(20, 1, "R9 full disable");
    wordMode = 1'b1;
    readOp(3, 1, "R5 single word read");
    special(2'b11, 1'b1);
    extInstr = 1'b0;
    wordMode = 1'b0;

    // busy overlapped with a new command (R10, R11)
    csOn();
    writeBits(40, 16'h0099, 0);
    check("R10 busy in same select", {15'd0, serOut}, 16'd0);
    csOff();
    modelWrite(40, 16'h0099);
    csOn();
    check("R10 busy low", {15'd0, serOut}, 16'd0);
    writeBits(41, 16'h0055, 0);                // dropped while busy
    check("R10 still busy", {15'd0, serOut}, 16'd0);
    csOff();
    tick(PROG);
    csOn();
    check("R11 ready high", {15'd0, serOut}, 16'd1);
    send(1'b1);
    check("R11 start clears status", {15'd0, serOut}, 16'd0);
    csOff();
    readOp(40, 2, "R10 busy overlap data");

    // abort a write mid data (R12)
    csOn();
    sendHdr(2'b01, 50, 0);
    for (int i = 0; i < 5; i++) send(1'b0);
    csOff();
    csOn();
    for (int i = 0; i < 3; i++) send(1'b1);    // stray bits after abort
    csOff();
    tick(PROG + 5);
    readOp(50, 1, "R12 aborted write");

    // random traffic
    for (int it = 0; it < 40; it++) begin
      wordMode = 1'($urandom_range(0, 1));
      extInstr = 1'($urandom_range(0, 1));
      a = wordMode ? $urandom_range(0, 63) : $urandom_range(0, 127);
      d = 16'($urandom);
      if (!wordMode) d[15:8] = 8'h00;
      if ($urandom_range(0, 1) == 1) writeOp(a, d, $urandom_range(0, 2));
      readOp(a, extInstr ? 1 : $urandom_range(1, 3), "R6 random");
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule